// File: doc/BRIEF.md
# Idle and Power-Down Mode Controller

This block decides which clocks of a small 8-bit microcontroller run. Software writes a two-bit mode register. One bit parks the processor in a light sleep: the CPU clock stops, and timers, the serial port and interrupt logic keep their clock. The other bit parks the whole device in a deep sleep: the oscillator enable drops and every clock stops. When software sets both bits, deep sleep takes precedence.

The two sleeps are left in different ways. An enabled interrupt ends light sleep. The controller clears the sleep bit itself and pulses a clear strobe, so the processor can service the interrupt straight away. Deep sleep ignores interrupts and ends only on a hardware reset. A reset request counts only after it has stayed high for two machine cycles of oscillator clocks, so short glitches are filtered out. The qualified reset initialises the special-function registers through a dedicated strobe, and RAM is outside its reach. After a deep-sleep exit, the register reset and the clock gating are held for an extra, parameterised stabilisation time, which gives the restarted oscillator time to settle.

A chip-level power-good signal (`por_n`) puts the controller into a known state at power-up.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: The mode register has bit 0 = light-sleep request and bit 1 = deep-sleep request, and it reads back on `mode_bits`. It is 2'b00 after power-up, with all three enables high. A write is sampled at a clock edge, and the new clock enables are visible directly after that edge.
- R2: When both bits are 1, deep sleep wins. The clock enables are those of deep sleep, and an interrupt does not clear the light-sleep bit.
- R3: In light sleep only (2'b01), `cpu_clk_en` is 0 while `per_clk_en` and `osc_run_en` stay 1.
- R4: In light sleep only, an `irq_pend` sampled at an edge clears bit 0 at that edge. It also raises `idle_clr` for exactly one cycle, and `cpu_clk_en` is 1 again directly after that edge.
- R5: While bit 1 is set and `ext_rst` is low, `cpu_clk_en`, `per_clk_en` and `osc_run_en` are all 0.
- R6: In deep sleep, `irq_pend` has no effect: the mode bits stay unchanged and `idle_clr` stays 0.
- R7: `sfr_rst` asserts only after `ext_rst` has been sampled high on OSC_PER_MC*QUAL_MC (default 24) consecutive edges. A shorter high pulse has no effect on the mode bits.
- R8: A qualified reset clears both mode bits, and so ends light sleep. Outside a deep-sleep exit, `sfr_rst` falls directly after the edge that samples `ext_rst` low.
- R9: While `ext_rst` is high, `osc_run_en` is 1. After a reset that ends deep sleep, `sfr_rst` stays 1 and both clock enables stay 0 for STAB_CYC edges after the edge that samples `ext_rst` low. Then all three enables are 1.
- R10: A register write made while `cpu_clk_en` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-good, active low |
| ext_rst | input | 1 | Synchronised hardware reset request, active high |
| ctl_we | input | 1 | Mode register write strobe |
| ctl_wdata | input | 2 | Write data: bit 0 light sleep, bit 1 deep sleep |
| irq_pend | input | 1 | An enabled interrupt is pending |
| mode_bits | output | 2 | Current mode register |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_run_en | output | 1 | Oscillator run enable |
| idle_clr | output | 1 | One-cycle strobe: hardware cleared light sleep |
| sfr_rst | output | 1 | Special-function register reset |

## Verification
The properties assume that `ext_rst` and `irq_pend` are already synchronous to `clk`. They also assume that the oscillator clock keeps toggling in simulation even while `osc_run_en` is low, so that the reset qualifier can observe the request. The stimulus changes every input one time unit after a rising edge. It only writes the mode register while the processor clock runs, apart from the deliberate writes that check R10. It sweeps reset pulse lengths across the qualification boundary, from a light-sleep start.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   typedef struct packed {
      logic pd;
      logic idl;
   } pmc_mode_t;

   localparam pmc_mode_t PMC_RUN = '{pd: 1'b0, idl: 1'b0};

   function automatic logic pmc_deep(input pmc_mode_t m);
      return m.pd;
   endfunction

   function automatic logic pmc_light(input pmc_mode_t m);
      return m.idl & ~m.pd;
   endfunction

endpackage

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
   parameter int QUAL = 24
) (
   input  logic clk,
   input  logic por_n,
   input  logic req,
   input  logic osc_on,
   output logic ok
);
   localparam int QW = $clog2(QUAL + 1);
   localparam logic [QW-1:0] QMAX = QW'(QUAL);

   logic [QW-1:0] cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         cnt <= '0;
      else if (!req)
         cnt <= '0;
      else if (osc_on && cnt != QMAX)
         cnt <= cnt + 1'b1;
   end

   assign ok = (cnt == QMAX);
endmodule

// File: rtl/pmc_stab_timer.sv
module pmc_stab_timer #(
   parameter int STAB = 1024
) (
   input  logic clk,
   input  logic por_n,
   input  logic load,
   output logic busy
);
   localparam int SW = $clog2(STAB + 1);
   localparam logic [SW-1:0] SMAX = SW'(STAB);

   logic [SW-1:0] cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         cnt <= '0;
      else if (load)
         cnt <= SMAX;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);
endmodule

// File: rtl/pmc_mode_reg.sv
module pmc_mode_reg
   import pmc_pkg::*;
(
   input  logic      clk,
   input  logic      por_n,
   input  logic      clr,
   input  logic      irq,
   input  logic      we,
   input  logic      we_ok,
   input  pmc_mode_t wdata,
   output pmc_mode_t mode,
   output logic      idle_clr
);
   logic wake;

   assign wake = irq & pmc_light(mode) & ~clr;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         mode     <= PMC_RUN;
         idle_clr <= 1'b0;
      end else begin
         idle_clr <= wake;
         if (clr)
            mode <= PMC_RUN;
         else if (wake)
            mode.idl <= 1'b0;
         else if (we && we_ok)
            mode <= wdata;
      end
   end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int OSC_PER_MC = 12,
   parameter int QUAL_MC    = 2,
   parameter int STAB_CYC   = 1024
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       ext_rst,
   input  logic       ctl_we,
   input  logic [1:0] ctl_wdata,
   input  logic       irq_pend,
   output logic [1:0] mode_bits,
   output logic       cpu_clk_en,
   output logic       per_clk_en,
   output logic       osc_run_en,
   output logic       idle_clr,
   output logic       sfr_rst
);
   localparam int QUAL = OSC_PER_MC * QUAL_MC;

   if (OSC_PER_MC < 1) begin : g_bad_mc
      $error("OSC_PER_MC must be at least 1");
   end
   if (QUAL_MC < 1) begin : g_bad_qual
      $error("QUAL_MC must be at least 1");
   end
   if (STAB_CYC < 0) begin : g_bad_stab
      $error("STAB_CYC must not be negative");
   end

   pmc_mode_t mode;
   pmc_mode_t wmode;
   logic      rst_ok;
   logic      stab_busy;

   assign wmode = '{pd: ctl_wdata[1], idl: ctl_wdata[0]};

   pmc_rst_qual #(.QUAL(QUAL)) u_qual (
      .clk    (clk),
      .por_n  (por_n),
      .req    (ext_rst),
      .osc_on (osc_run_en),
      .ok     (rst_ok)
   );

   if (STAB_CYC > 0) begin : g_stab
      pmc_stab_timer #(.STAB(STAB_CYC)) u_stab (
         .clk   (clk),
         .por_n (por_n),
         .load  (rst_ok & (mode.pd | stab_busy)),
         .busy  (stab_busy)
      );
   end else begin : g_nostab
      assign stab_busy = 1'b0;
   end

   assign sfr_rst = rst_ok | stab_busy;

   pmc_mode_reg u_mode (
      .clk      (clk),
      .por_n    (por_n),
      .clr      (sfr_rst),
      .irq      (irq_pend),
      .we       (ctl_we),
      .we_ok    (cpu_clk_en),
      .wdata    (wmode),
      .mode     (mode),
      .idle_clr (idle_clr)
   );

   assign cpu_clk_en = ~stab_busy & ~mode.pd & ~mode.idl;
   assign per_clk_en = ~stab_busy & ~pmc_deep(mode);
   assign osc_run_en = ~mode.pd | ext_rst;
   assign mode_bits  = {mode.pd, mode.idl};
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk (
   input logic       clk,
   input logic       por_n,
   input logic       ext_rst,
   input logic       ctl_we,
   input logic       irq_pend,
   input logic [1:0] mode_bits,
   input logic       cpu_clk_en,
   input logic       per_clk_en,
   input logic       osc_run_en,
   input logic       idle_clr,
   input logic       sfr_rst
);
   a_r2_deep_wins: assert property (@(posedge clk) disable iff (!por_n)
      (mode_bits == 2'b11) |-> (!cpu_clk_en && !per_clk_en));

   a_r3_light_gating: assert property (@(posedge clk) disable iff (!por_n)
      (mode_bits == 2'b01) |-> (!cpu_clk_en && per_clk_en && osc_run_en));

   a_r4_irq_wakes: assert property (@(posedge clk) disable iff (!por_n)
      (mode_bits == 2'b01 && irq_pend && !sfr_rst) |=> (idle_clr && !mode_bits[0]));

   a_r5_deep_gating: assert property (@(posedge clk) disable iff (!por_n)
      (mode_bits[1] && !ext_rst) |-> (!cpu_clk_en && !per_clk_en && !osc_run_en));

   a_r6_deep_no_irq: assert property (@(posedge clk) disable iff (!por_n)
      (mode_bits[1] && !sfr_rst && !ext_rst) |=> (mode_bits[1] && !idle_clr));

   a_r7_rst_needs_req: assert property (@(posedge clk) disable iff (!por_n)
      $rose(sfr_rst) |-> $past(ext_rst));

   a_r9_osc_on_reset: assert property (@(posedge clk) disable iff (!por_n)
      ext_rst |-> osc_run_en);

   a_r10_gated_write: assert property (@(posedge clk) disable iff (!por_n)
      (!cpu_clk_en && ctl_we && !irq_pend && !ext_rst) |=> $stable(mode_bits));
endmodule

bind pwr_mode_ctrl pmc_chk u_chk (
   .clk        (clk),
   .por_n      (por_n),
   .ext_rst    (ext_rst),
   .ctl_we     (ctl_we),
   .irq_pend   (irq_pend),
   .mode_bits  (mode_bits),
   .cpu_clk_en (cpu_clk_en),
   .per_clk_en (per_clk_en),
   .osc_run_en (osc_run_en),
   .idle_clr   (idle_clr),
   .sfr_rst    (sfr_rst)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
   localparam int STAB = 5;
   localparam int QUAL = 24;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       ext_rst = 1'b0;
   logic       ctl_we = 1'b0;
   logic [1:0] ctl_wdata = 2'b00;
   logic       irq_pend = 1'b0;
   logic [1:0] mode_bits;
   logic       cpu_clk_en, per_clk_en, osc_run_en, idle_clr, sfr_rst;

   int n_chk = 0;
   int n_bad = 0;
   bit done_flag = 0;

   always #2.5 clk = ~clk;

   pwr_mode_ctrl #(.OSC_PER_MC(12), .QUAL_MC(2), .STAB_CYC(STAB)) u0 (
      .clk(clk), .por_n(por_n), .ext_rst(ext_rst), .ctl_we(ctl_we),
      .ctl_wdata(ctl_wdata), .irq_pend(irq_pend), .mode_bits(mode_bits),
      .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_run_en(osc_run_en),
      .idle_clr(idle_clr), .sfr_rst(sfr_rst)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // {mode, cpu, per, osc, sfr_rst}
   function automatic logic [7:0] st();
      return {2'b00, mode_bits, cpu_clk_en, per_clk_en, osc_run_en, sfr_rst};
   endfunction

   task automatic wr(input logic [1:0] d);
      ctl_we = 1'b1; ctl_wdata = d;
      tick(1);
      ctl_we = 1'b0;
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      tick(3);
      por_n = 1'b1;
      tick(1);
      // R1 reset state
      chk("R1 reset", st(), {2'b00, 2'b00, 4'b1110});

      // R3 light sleep, R1 write timing
      wr(2'b01);
      chk("R3 light", st(), {2'b00, 2'b01, 4'b0110});
      // R10 write ignored while gated
      wr(2'b10);
      chk("R10 ignored", st(), {2'b00, 2'b01, 4'b0110});
      // R4 interrupt wakes
      irq_pend = 1'b1; tick(1); irq_pend = 1'b0;
      chk("R4 wake", {idle_clr, st()[6:0]}, {1'b1, 1'b0, 2'b00, 4'b1110});
      tick(1);
      chk("R4 pulse one cycle", {7'b0, idle_clr}, 8'h00);

      // R5 deep sleep
      wr(2'b10);
      chk("R5 deep", st(), {2'b00, 2'b10, 4'b0000});
      // R6 interrupt ignored
      irq_pend = 1'b1; tick(1); irq_pend = 1'b0;
      chk("R6 irq in deep", {idle_clr, st()[6:0]}, {1'b0, 1'b0, 2'b10, 4'b0000});

      // R9 deep exit with stabilisation
      ext_rst = 1'b1; #0.5;
      chk("R9 osc on reset", {7'b0, osc_run_en}, 8'h01);
      tick(QUAL - 1);
      chk("R7 not yet", {7'b0, sfr_rst}, 8'h00);
      tick(1);
      chk("R7 qualified", {7'b0, sfr_rst}, 8'h01);
      ext_rst = 1'b0;
      tick(1);
      chk("R9 hold start", st(), {2'b00, 2'b00, 4'b0011});
      tick(STAB - 1);
      chk("R9 hold end", st(), {2'b00, 2'b00, 4'b0011});
      tick(1);
      chk("R9 released", st(), {2'b00, 2'b00, 4'b1110});

      // R2 both bits: deep wins
      wr(2'b11);
      chk("R2 both", st(), {2'b00, 2'b11, 4'b0000});
      irq_pend = 1'b1; tick(1); irq_pend = 1'b0;
      chk("R2 irq kept", {idle_clr, st()[6:0]}, {1'b0, 1'b0, 2'b11, 4'b0000});
      ext_rst = 1'b1; tick(QUAL + 1); ext_rst = 1'b0;
      tick(STAB + 1);
      chk("R2 exit", st(), {2'b00, 2'b00, 4'b1110});

      // R7 / R8 sweep of pulse lengths from light sleep
      for (int k = 1; k <= 30; k++) begin
         irq_pend = 1'b1; tick(1); irq_pend = 1'b0;
         wr(2'b01);
         ext_rst = 1'b1;
         tick(k);
         chk("R7 sweep qual", {7'b0, sfr_rst}, {7'b0, (k >= QUAL)});
         ext_rst = 1'b0;
         tick(1);
         // R8 mode cleared only by a qualified reset, strobe drops at once
         chk("R8 sweep mode", st(),
             (k >= QUAL) ? {2'b00, 2'b00, 4'b1110} : {2'b00, 2'b01, 4'b0110});
      end
      finish_run();
   end
endmodule